// File: doc/BRIEF.md
# Synchronous Rectifier Phase Delay/Advance Unit

This block sits between the bridge sequencer and the gate drivers of a phase-shifted full bridge. It takes the two lower-bridge PWM signals and the two upper 50% signals. It forms the two synchronous-rectifier drive signals, and each of them is the complement of the lower PWM signal on the opposite side. A signed phase-adjust code then chooses which of the two groups is delayed. One group is the lower PWM outputs together with the upper outputs. The other group is the rectifier outputs. Only one group is ever delayed, so the rectifier edges move earlier or later against the bridge edges.

The code is folded into a delay in clock cycles. A small dead band around zero gives no delay. Outside the band the delay grows quadratically from a minimum to a maximum: steps are fine near the band and coarse at full scale. When the bridge group is delayed, the delay is limited to 90% of the current deadtime. The code and the deadtime are sampled only on an oscillator-period strobe. Each signal passes through a shift register with a selectable tap, so a pulse keeps its exact width. Every output carries one base register stage in addition to the selected delay. A disable input forces all six outputs low at once. These are level control signals with no flow control, so the block has no valid/ready handshake.

Top module: `srdly_unit`

## Requirements
- R1: The left rectifier output is the inverse of the right lower PWM input, and the right rectifier output is the inverse of the left lower PWM input. With zero delay, an output in cycle k shows the input sampled at the clock edge that opens cycle k (one register stage).
- R2: When both lower PWM inputs stay low, as with a zero duty command, both rectifier outputs are high and both lower outputs are low.
- R3: An adjust code with magnitude of at most DB (default 3) adds no delay to any output.
- R4: A code below -DB delays the lower and upper outputs by the mapped number of cycles and leaves the rectifier outputs undelayed. The upper outputs always get exactly the same delay as the lower outputs.
- R5: A code above +DB delays both rectifier outputs by the mapped number of cycles and leaves the lower and upper outputs undelayed.
- R6: For magnitude m > DB, the mapped delay is MIN_DLY + floor((m-DB-1)^2 * (MAX_DLY-MIN_DLY) / XMAX^2), where XMAX = 2^(CODE_W-1) - DB - 1. With the defaults (8-bit code, DB 3, MIN 8, MAX 60) this gives 8 at |code| 4, 10 at -32, 20 at -64, 59 at +127 and 60 at -128.
- R7: When the bridge group is delayed, its delay is min(mapped, floor(9*deadtime/10)), where deadtime is the deadtime input in cycles.
- R8: A delayed pulse has the same width in cycles as the input pulse.
- R9: The adjust code and the deadtime are sampled only in a cycle with the oscillator strobe high. The new delays apply from the next cycle. A code change in any other cycle has no effect until the next strobe.
- R10: While the disable input is high, all six outputs are low in the same cycle.
- R11: During reset all outputs are low and both delays are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe at each oscillator-period boundary |
| dis | input | 1 | Global disable; forces all outputs low |
| low_l_i | input | 1 | Left lower PWM from the sequencer |
| low_r_i | input | 1 | Right lower PWM from the sequencer |
| up_l_i | input | 1 | Left upper 50% signal |
| up_r_i | input | 1 | Right upper 50% signal |
| adj_code | input | CODE_W | Signed phase-adjust code (two's complement) |
| dead_cyc | input | DT_W | Current deadtime in clock cycles |
| low_l_o | output | 1 | Phase-aligned left lower PWM |
| low_r_o | output | 1 | Phase-aligned right lower PWM |
| up_l_o | output | 1 | Phase-aligned left upper signal |
| up_r_o | output | 1 | Phase-aligned right upper signal |
| sr_l_o | output | 1 | Left rectifier drive |
| sr_r_o | output | 1 | Right rectifier drive |

## Verification
A sample taken in cycle k of an output whose group delay is d must equal the input driven d+1 cycles earlier, and the bench keeps a history of every input it drove so it can look that value up. It also keeps its own copy of both delays. That copy changes only when the bench itself drives the strobe, and the bench applies it from the next sample on. It therefore expects a code written between strobes to have no effect for the rest of the period. Outputs are sampled at the falling edge, before new inputs are driven. The one exception is disable: it acts without a register, so it is checked one time step after it is driven, within the same cycle.

// File: rtl/srdly_pkg.sv
package srdly_pkg;

  // Bridge group bit order inside the delay line
  localparam int BR_LL = 0;
  localparam int BR_LR = 1;
  localparam int BR_UL = 2;
  localparam int BR_UR = 3;
  localparam int BR_W  = 4;

  // Rectifier group bit order
  localparam int RC_L = 0;
  localparam int RC_R = 1;
  localparam int RC_W = 2;

  // Quadratic code-magnitude to delay shaping
  function automatic int shape_delay(input int mag, input int band,
                                     input int dmin, input int dmax,
                                     input int xmax);
    int x;
    if (mag <= band) return 0;
    x = mag - band - 1;
    return dmin + (x * x * (dmax - dmin)) / (xmax * xmax);
  endfunction

endpackage

// File: rtl/srdly_map.sv
module srdly_map
  import srdly_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int DT_W    = 8,
  parameter int DB      = 3,
  parameter int MIN_DLY = 8,
  parameter int MAX_DLY = 60,
  parameter int IDX_W   = $clog2(MAX_DLY + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     osc_tick,
  input  logic signed [CODE_W-1:0] adj_code,
  input  logic [DT_W-1:0]          dead_cyc,
  output logic [IDX_W-1:0]         pwm_dly,
  output logic [IDX_W-1:0]         sr_dly
);

  localparam int XMAX = (1 << (CODE_W - 1)) - DB - 1;

  int mag;
  int raw;
  int lim;
  int pwm_n;
  int sr_n;

  always_comb begin
    mag   = adj_code[CODE_W-1] ? -int'(adj_code) : int'(adj_code);
    raw   = shape_delay(mag, DB, MIN_DLY, MAX_DLY, XMAX);
    lim   = (int'(dead_cyc) * 9) / 10;
    pwm_n = 0;
    sr_n  = 0;
    if (raw > 0) begin
      if (adj_code[CODE_W-1]) pwm_n = (raw > lim) ? lim : raw;
      else                    sr_n  = raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_dly <= '0;
      sr_dly  <= '0;
    end else if (osc_tick) begin
      pwm_dly <= pwm_n[IDX_W-1:0];
      sr_dly  <= sr_n[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/srdly_line.sv
module srdly_line #(
  parameter int W     = 4,
  parameter int DEPTH = 61,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] tap,
  output logic [W-1:0]     dout
);

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else        stage[g] <= stage[g-1];
    end
  end

  always_comb begin
    if (int'(tap) < DEPTH) dout = stage[tap];
    else                   dout = stage[DEPTH-1];
  end

endmodule

// File: rtl/srdly_gate.sv
module srdly_gate #(
  parameter int W = 6
) (
  input  logic         dis,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  assign dout = dis ? '0 : din;

endmodule

// File: rtl/srdly_unit.sv
module srdly_unit
  import srdly_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int DT_W    = 8,
  parameter int DB      = 3,
  parameter int MIN_DLY = 8,
  parameter int MAX_DLY = 60
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     osc_tick,
  input  logic                     dis,
  input  logic                     low_l_i,
  input  logic                     low_r_i,
  input  logic                     up_l_i,
  input  logic                     up_r_i,
  input  logic signed [CODE_W-1:0] adj_code,
  input  logic [DT_W-1:0]          dead_cyc,
  output logic                     low_l_o,
  output logic                     low_r_o,
  output logic                     up_l_o,
  output logic                     up_r_o,
  output logic                     sr_l_o,
  output logic                     sr_r_o
);

  localparam int DEPTH = MAX_DLY + 1;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OUT_W = BR_W + RC_W;

  logic [IDX_W-1:0] pwm_dly;
  logic [IDX_W-1:0] sr_dly;
  logic [BR_W-1:0]  br_src, br_dly;
  logic [RC_W-1:0]  rc_src, rc_dly;
  logic [OUT_W-1:0] out_vec;

  srdly_map #(
    .CODE_W(CODE_W), .DT_W(DT_W), .DB(DB),
    .MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY), .IDX_W(IDX_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .adj_code(adj_code), .dead_cyc(dead_cyc),
    .pwm_dly(pwm_dly), .sr_dly(sr_dly)
  );

  // Bridge group: lower PWM and upper 50% share one delay
  always_comb begin
    br_src        = '0;
    br_src[BR_LL] = low_l_i;
    br_src[BR_LR] = low_r_i;
    br_src[BR_UL] = up_l_i;
    br_src[BR_UR] = up_r_i;
    // Each rectifier follows the inverse of the opposite lower switch
    rc_src        = '0;
    rc_src[RC_L]  = ~low_r_i;
    rc_src[RC_R]  = ~low_l_i;
  end

  srdly_line #(.W(BR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_br_line (
    .clk(clk), .rst_n(rst_n), .din(br_src), .tap(pwm_dly), .dout(br_dly)
  );

  srdly_line #(.W(RC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_rc_line (
    .clk(clk), .rst_n(rst_n), .din(rc_src), .tap(sr_dly), .dout(rc_dly)
  );

  srdly_gate #(.W(OUT_W)) u_gate (
    .dis(dis), .din({rc_dly, br_dly}), .dout(out_vec)
  );

  assign low_l_o = out_vec[BR_LL];
  assign low_r_o = out_vec[BR_LR];
  assign up_l_o  = out_vec[BR_UL];
  assign up_r_o  = out_vec[BR_UR];
  assign sr_l_o  = out_vec[BR_W + RC_L];
  assign sr_r_o  = out_vec[BR_W + RC_R];

endmodule

// File: rtl/srdly_chk.sv
module srdly_chk #(
  parameter int DT_W    = 8,
  parameter int MIN_DLY = 8,
  parameter int MAX_DLY = 60,
  parameter int IDX_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             dis,
  input logic             low_l_i,
  input logic             low_r_i,
  input logic [DT_W-1:0]  dead_cyc,
  input logic [IDX_W-1:0] pwm_dly,
  input logic [IDX_W-1:0] sr_dly,
  input logic             low_l_o,
  input logic             low_r_o,
  input logic             up_l_o,
  input logic             up_r_o,
  input logic             sr_l_o,
  input logic             sr_r_o
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R10
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> !(low_l_o || low_r_o || up_l_o || up_r_o || sr_l_o || sr_r_o));

  // R4
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((pwm_dly != '0) && (sr_dly != '0)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> ($stable(pwm_dly) && $stable(sr_dly)));

  // R7
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick |=> (int'(pwm_dly) * 10 <= int'($past(dead_cyc)) * 9));

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_dly != '0) |-> (int'(sr_dly) >= MIN_DLY && int'(sr_dly) <= MAX_DLY));

  // R1
  comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !dis && sr_dly == '0) |->
      (sr_l_o == !$past(low_r_i) && sr_r_o == !$past(low_l_i)));

endmodule

bind srdly_unit srdly_chk #(
  .DT_W(DT_W), .MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .dis(dis),
  .low_l_i(low_l_i), .low_r_i(low_r_i), .dead_cyc(dead_cyc),
  .pwm_dly(pwm_dly), .sr_dly(sr_dly),
  .low_l_o(low_l_o), .low_r_o(low_r_o), .up_l_o(up_l_o), .up_r_o(up_r_o),
  .sr_l_o(sr_l_o), .sr_r_o(sr_r_o)
);

// File: tb/tb_srdly_unit.sv
`timescale 1ns/1ps
module tb_srdly_unit;

  localparam int P    = 20;    // steps per half period
  localparam int HLEN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic dis = 1'b0;
  logic low_l_i = 1'b0, low_r_i = 1'b0, up_l_i = 1'b0, up_r_i = 1'b0;
  logic signed [7:0] adj_code = '0;
  logic [7:0] dead_cyc = 8'd100;
  logic low_l_o, low_r_o, up_l_o, up_r_o, sr_l_o, sr_r_o;

  always #2.5 clk = ~clk;

  srdly_unit dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .dis(dis),
    .low_l_i(low_l_i), .low_r_i(low_r_i), .up_l_i(up_l_i), .up_r_i(up_r_i),
    .adj_code(adj_code), .dead_cyc(dead_cyc),
    .low_l_o(low_l_o), .low_r_o(low_r_o), .up_l_o(up_l_o), .up_r_o(up_r_o),
    .sr_l_o(sr_l_o), .sr_r_o(sr_r_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [3:0] hist [HLEN];   // {ur, ul, lr, ll} as driven
  int step_c = 0;
  int cur_w = 7;
  int m_pwm = 0;             // bench copy of delays
  int m_sr = 0;
  int hi_cnt;
  bit run_err;
  string run_msg;

  function automatic int map_mag(input int m);
    int x;
    if (m <= 3) return 0;
    x = m - 4;
    return 8 + (x * x * 52) / (124 * 124);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: sample outputs, then drive next inputs
  task automatic step();
    logic [3:0] eb, es;
    logic [5:0] act, exp;
    int ip, is, pos, half, cd;
    @(negedge clk);
    ip = step_c - 1 - m_pwm;
    is = step_c - 1 - m_sr;
    if (ip >= 0 && is >= 0) begin
      eb = hist[ip % HLEN];
      es = hist[is % HLEN];
      exp = {~es[0], ~es[1], eb[3], eb[2], eb[1], eb[0]};
      if (dis) exp = '0;
      act = {sr_r_o, sr_l_o, up_r_o, up_l_o, low_r_o, low_l_o};
      if (act !== exp && !run_err) begin
        run_err = 1;
        run_msg = $sformatf("step %0d outputs %b vs %b", step_c, act, exp);
      end
    end
    if (low_l_o) hi_cnt++;
    pos  = step_c % P;
    half = (step_c / P) % 2;
    up_l_i   = (half == 0);
    up_r_i   = (half == 1);
    low_l_i  = (half == 0) && (pos < cur_w);
    low_r_i  = (half == 1) && (pos < cur_w);
    osc_tick = (pos == 0);
    hist[step_c % HLEN] = {up_r_i, up_l_i, low_r_i, low_l_i};
    if (osc_tick) begin
      cd = int'(adj_code);
      m_pwm = 0;
      m_sr = 0;
      if (cd < 0) begin
        m_pwm = map_mag(-cd);
        if (m_pwm > (int'(dead_cyc) * 9) / 10) m_pwm = (int'(dead_cyc) * 9) / 10;
      end else begin
        m_sr = map_mag(cd);
      end
    end
    step_c++;
  endtask

  task automatic run(input int n, input string req);
    run_err = 0;
    run_msg = "";
    hi_cnt = 0;
    for (int i = 0; i < n; i++) step();
    n_chk++;
    if (run_err) begin
      n_bad++;
      $display("FAIL %s %s", req, run_msg);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({low_l_o, low_r_o, up_l_o, up_r_o, sr_l_o, sr_r_o} == 6'b0,
          "R11", "outputs in reset", int'({low_l_o, low_r_o, up_l_o, up_r_o, sr_l_o, sr_r_o}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_band();
    adj_code = 8'sd0;  run(60, "R1 R3 code 0");
    adj_code = 8'sd3;  run(60, "R3 code +3");
    adj_code = -8'sd3; run(60, "R3 code -3");
  endtask

  task automatic t_zero_duty();
    cur_w = 0;
    run(60, "R2 zero duty stream");
    check(sr_l_o && sr_r_o && !low_l_o && !low_r_o, "R2", "freewheel levels",
          int'({sr_l_o, sr_r_o, low_l_o, low_r_o}), 4'b1100);
    cur_w = 7;
  endtask

  task automatic t_bridge();
    dead_cyc = 8'd100;
    adj_code = -8'sd128; run(200, "R4 R6 code -128 delay 60");
    adj_code = -8'sd64;  run(150, "R4 R6 code -64 delay 20");
    adj_code = -8'sd32;  run(150, "R6 code -32 delay 10");
  endtask

  task automatic t_rect();
    adj_code = 8'sd4;   run(150, "R5 R6 code +4 delay 8");
    adj_code = 8'sd127; run(200, "R5 R6 code +127 delay 59");
  endtask

  task automatic t_clamp();
    dead_cyc = 8'd40;
    adj_code = -8'sd128; run(200, "R7 clamp to 36");
    dead_cyc = 8'd100;
  endtask

  task automatic t_width();
    adj_code = -8'sd64; cur_w = 9;
    run(80, "R8 settle");
    run(2 * P, "R8 window");
    check(hi_cnt == 9, "R8", "delayed pulse width", hi_cnt, 9);
    cur_w = 7;
  endtask

  task automatic t_between();
    adj_code = 8'sd0;
    run(60, "R9 settle");
    while (step_c % P != 5) step();
    adj_code = -8'sd128;
    run(10, "R9 code ignored before strobe");
    check(m_pwm == 0, "R9", "bench delay before strobe", m_pwm, 0);
    run(150, "R9 applied after strobe");
  endtask

  task automatic t_dis();
    adj_code = 8'sd20;
    run(40, "R10 settle");
    @(negedge clk);
    dis = 1'b1;
    #1;
    check({low_l_o, low_r_o, up_l_o, up_r_o, sr_l_o, sr_r_o} == 6'b0,
          "R10", "outputs on disable", int'({low_l_o, low_r_o, up_l_o, up_r_o, sr_l_o, sr_r_o}), 0);
    run(30, "R10 held low");
    dis = 1'b0;
    run(80, "R10 release");
  endtask

  initial begin
    t_reset();
    t_band();
    t_zero_duty();
    t_bridge();
    t_rect();
    t_clamp();
    t_width();
    t_between();
    t_dis();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule